// File: doc/BRIEF.md
# Boundary-Conduction Boost Gate Controller

This block drives the gate-enable of a boost converter switch that runs at the edge between continuous and discontinuous inductor conduction. It has no switching clock of its own. A cycle begins when the inductor current has fallen to zero and ends when the sensed switch current reaches its commanded peak. Three digital inputs feed it. The first is the output of the zero-current comparator, which is high while the auxiliary winding voltage sits above its upper hysteresis threshold and low once it drops below the lower one. The second is a trip flag from the current-sense comparator, which fires on either the multiplier reference or the absolute peak clamp. The third is a combined inhibit, raised by supply lockout, disable, overvoltage or zero-power detection.

Both comparator inputs are asynchronous and pass through synchronizers. The trip path has two defences against switching noise: a leading-edge blanking window at the start of every on-time, and a persistence filter that rejects short spikes. A restart timer guarantees a pulse when no zero crossing arrives, which also starts the converter after reset. The gate state is one register whose clear requests override its set requests.

Top module: `tm_gate_ctrl`

## Requirements
- R1: While rst_n is low, and on the first samples after it is released, gate_o is 0.
- R2: With no zero-current edge after reset release, gate_o first goes to 1 exactly RESTART_CYCLES clock edges after the release.
- R3: With blanking over, a trip_i level held high turns gate_o off exactly SYNC_STAGES + TRIP_FILT_CYCLES clock edges after trip_i is driven high.
- R4: A trip during the first BLANK_CYCLES cycles of an on-time has no effect. If trip_i is driven high in the same cycle the gate turns on, the on-time lasts max(BLANK_CYCLES + 1, SYNC_STAGES + TRIP_FILT_CYCLES) cycles.
- R5: A trip_i pulse shorter than TRIP_FILT_CYCLES cycles leaves gate_o high.
- R6: While the gate is off, a high level on zcd_i does not turn the gate on. A falling edge of zcd_i that follows a high level seen while the gate is off turns gate_o on SYNC_STAGES + 1 edges after zcd_i is driven low.
- R7: A zcd_i high-then-low during the on-time does not arm a turn-on. If zcd_i then stays low, the gate turns on again exactly RESTART_CYCLES edges after it turned off.
- R8: After the gate has been held off by the inhibit for longer than the restart interval, gate_o turns on at the first edge after inhibit_i is released.
- R9: inhibit_i high forces gate_o to 0 at the next clock edge, and it stays 0 while inhibit_i remains high, whatever zcd_i does.
- R10: A qualified trip overrides turn-on requests. While trip_i is held, neither a valid zero-current edge nor timer expiry turns the gate on. Once trip_i is released, the pending request turns the gate on SYNC_STAGES + 1 edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zcd_i | input | 1 | Zero-current comparator output, high above upper threshold, asynchronous |
| trip_i | input | 1 | Current-sense trip flag (reference or peak clamp), asynchronous |
| inhibit_i | input | 1 | Combined hold-off (lockout, disable, overvoltage, zero power), synchronous |
| gate_o | output | 1 | Gate-drive enable |

## Verification
The bench measures edge-exact latencies for timer restart, trip turn-off and zero-current turn-on. A design that miscounted a synchronizer stage or the timer limit would show a shifted pulse. It applies a trip at the very instant of turn-on, so a design without blanking would give an on-time two cycles short, and it sends a trip spike one cycle shorter than the filter, which an unfiltered design would treat as a real turn-off. It toggles zcd_i during the on-time and then leaves it low, which catches a design that arms on stale levels and would fire early instead of waiting for the timer. It also holds a trip across both a valid zero-current edge and timer expiry, which exposes a set-dominant latch as a stray pulse.

// File: rtl/tm_gate_pkg.sv
`timescale 1ns/1ps
package tm_gate_pkg;

   // Requests presented to the gate state register in one cycle.
   typedef struct packed {
      logic zcd_set;
      logic tmr_set;
      logic trip_clr;
      logic inh_clr;
   } gate_req_t;

   // Clear requests take priority over set requests.
   function automatic logic gate_next(input gate_req_t r, input logic cur);
      logic clr_any;
      logic set_any;
      clr_any = r.trip_clr | r.inh_clr;
      set_any = r.zcd_set  | r.tmr_set;
      if (clr_any)      return 1'b0;
      else if (set_any) return 1'b1;
      else              return cur;
   endfunction

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/tm_sync.sv
`timescale 1ns/1ps
module tm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sr;
         for (genvar k = 0; k < STAGES; k++) begin : g_stage
            if (k == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) sr[0] <= 1'b0;
                  else        sr[0] <= d;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) sr[k] <= 1'b0;
                  else        sr[k] <= sr[k-1];
               end
            end
         end
         assign q = sr[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/tm_zcd_arm.sv
`timescale 1ns/1ps
module tm_zcd_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic zcd_s,
   input  logic gate_q,
   input  logic inhibit_i,
   output logic set_o
);
   logic armed;

   // Arm only on a high level seen while the switch is off and not inhibited.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  armed <= 1'b0;
      else if (gate_q || inhibit_i) armed <= 1'b0;
      else if (zcd_s)              armed <= 1'b1;
   end

   assign set_o = armed & ~zcd_s & ~gate_q;
endmodule

// File: rtl/tm_trip_qual.sv
`timescale 1ns/1ps
module tm_trip_qual #(
   parameter int unsigned FILT_CYCLES  = 3,
   parameter int unsigned BLANK_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trip_s,
   input  logic gate_q,
   output logic trip_o,
   output logic blank_o
);
   import tm_gate_pkg::*;

   logic trip_ok;

   // Persistence filter: trip must be seen on FILT_CYCLES consecutive clocks.
   generate
      if (FILT_CYCLES <= 1) begin : g_nofilt
         assign trip_ok = trip_s;
      end else begin : g_filt
         localparam int unsigned FW = cnt_width(FILT_CYCLES);
         localparam logic [FW-1:0] RUN_TOP = FW'(FILT_CYCLES - 1);
         logic [FW-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            run <= '0;
            else if (!trip_s)      run <= '0;
            else if (run != RUN_TOP) run <= run + 1'b1;
         end
         assign trip_ok = trip_s & (run == RUN_TOP);
      end
   endgenerate

   // Leading-edge blanking at the start of every on-time.
   generate
      if (BLANK_CYCLES == 0) begin : g_noblank
         assign blank_o = 1'b0;
      end else begin : g_blank
         localparam int unsigned BW = cnt_width(BLANK_CYCLES + 1);
         logic [BW-1:0] bcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          bcnt <= BW'(BLANK_CYCLES);
            else if (!gate_q)    bcnt <= BW'(BLANK_CYCLES);
            else if (bcnt != '0) bcnt <= bcnt - 1'b1;
         end
         assign blank_o = gate_q & (bcnt != '0);
      end
   endgenerate

   assign trip_o = trip_ok & ~blank_o;
endmodule

// File: rtl/tm_restart_tmr.sv
`timescale 1ns/1ps
module tm_restart_tmr #(
   parameter int unsigned RESTART_CYCLES = 40000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_q,
   output logic expire_o
);
   import tm_gate_pkg::*;

   localparam int unsigned CW = cnt_width(RESTART_CYCLES);
   localparam logic [CW-1:0] CNT_TOP = CW'(RESTART_CYCLES - 1);

   logic [CW-1:0] cnt;

   // Held at zero during the on-time, counts off-time, saturates at the limit.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (gate_q)         cnt <= '0;
      else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
   end

   assign expire_o = ~gate_q & (cnt == CNT_TOP);
endmodule

// File: rtl/tm_gate_ctrl.sv
`timescale 1ns/1ps
module tm_gate_ctrl #(
   parameter int unsigned SYNC_STAGES        = 2,
   parameter int unsigned TRIP_FILT_CYCLES   = 3,
   parameter int unsigned BLANK_CYCLES       = 16,
   parameter int unsigned RESTART_CYCLES     = 40000,
   parameter int unsigned MIN_RESTART_CYCLES = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic zcd_i,
   input  logic trip_i,
   input  logic inhibit_i,
   output logic gate_o
);
   import tm_gate_pkg::*;

   generate
      if (MIN_RESTART_CYCLES < 2) begin : g_bad_min
         $error("MIN_RESTART_CYCLES must be at least 2");
      end
      if (RESTART_CYCLES < MIN_RESTART_CYCLES) begin : g_bad_restart
         $error("RESTART_CYCLES below MIN_RESTART_CYCLES");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES above 4");
      end
   endgenerate

   logic zcd_s;
   logic trip_s;
   logic gate_q;
   logic set_zcd;
   logic expire;
   logic trip_qual;
   logic blank_act;
   logic set_any;
   gate_req_t req;

   tm_sync #(.STAGES(SYNC_STAGES)) u_sync_zcd (
      .clk(clk), .rst_n(rst_n), .d(zcd_i), .q(zcd_s)
   );

   tm_sync #(.STAGES(SYNC_STAGES)) u_sync_trip (
      .clk(clk), .rst_n(rst_n), .d(trip_i), .q(trip_s)
   );

   tm_zcd_arm u_arm (
      .clk(clk), .rst_n(rst_n), .zcd_s(zcd_s), .gate_q(gate_q),
      .inhibit_i(inhibit_i), .set_o(set_zcd)
   );

   tm_trip_qual #(
      .FILT_CYCLES(TRIP_FILT_CYCLES), .BLANK_CYCLES(BLANK_CYCLES)
   ) u_trip (
      .clk(clk), .rst_n(rst_n), .trip_s(trip_s), .gate_q(gate_q),
      .trip_o(trip_qual), .blank_o(blank_act)
   );

   tm_restart_tmr #(.RESTART_CYCLES(RESTART_CYCLES)) u_tmr (
      .clk(clk), .rst_n(rst_n), .gate_q(gate_q), .expire_o(expire)
   );

   always_comb begin
      req.zcd_set  = set_zcd;
      req.tmr_set  = expire;
      req.trip_clr = trip_qual;
      req.inh_clr  = inhibit_i;
   end

   assign set_any = req.zcd_set | req.tmr_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= gate_next(req, gate_q);
   end

   assign gate_o = gate_q;
endmodule

// File: rtl/tm_gate_ctrl_chk.sv
`timescale 1ns/1ps
module tm_gate_ctrl_chk #(
   parameter int unsigned RESTART_CYCLES = 40000
) (
   input logic clk,
   input logic rst_n,
   input logic inhibit_i,
   input logic gate_o,
   input logic trip_qual,
   input logic set_any,
   input logic blank_act
);
   localparam int unsigned RW = $clog2(RESTART_CYCLES + 1);

   logic [RW-1:0] off_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               off_run <= '0;
      else if (gate_o || inhibit_i || trip_qual) off_run <= '0;
      else if (off_run != RW'(RESTART_CYCLES))  off_run <= off_run + 1'b1;
   end

   // R9
   inhibit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit_i |=> !gate_o);

   // R4
   blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o && blank_act && !inhibit_i) |=> gate_o);

   // R7
   restart_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gate_o |-> (off_run < RW'(RESTART_CYCLES)));

   // R10
   clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_any && trip_qual) |=> !gate_o);

   // R3
   fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_o) |-> $past(trip_qual || inhibit_i));
endmodule

bind tm_gate_ctrl tm_gate_ctrl_chk #(.RESTART_CYCLES(RESTART_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .inhibit_i(inhibit_i), .gate_o(gate_o),
   .trip_qual(trip_qual), .set_any(set_any), .blank_act(blank_act)
);

// File: tb/test_tm_gate_ctrl.sv
`timescale 1ns/1ps
module test_tm_gate_ctrl;
   localparam int SYNC  = 2;
   localparam int FILT  = 3;
   localparam int BLANK = 6;
   localparam int RST_C = 64;
   localparam int LAT_TRIP = SYNC + FILT;
   localparam int LAT_ZCD  = SYNC + 1;
   localparam int ON_BLANKED = (BLANK + 1 > LAT_TRIP) ? BLANK + 1 : LAT_TRIP;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic zcd_i = 1'b0;
   logic trip_i = 1'b0;
   logic inhibit_i = 1'b0;
   logic gate_o;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   tm_gate_ctrl #(
      .SYNC_STAGES(SYNC), .TRIP_FILT_CYCLES(FILT), .BLANK_CYCLES(BLANK),
      .RESTART_CYCLES(RST_C), .MIN_RESTART_CYCLES(32)
   ) i_tm_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .zcd_i(zcd_i), .trip_i(trip_i),
      .inhibit_i(inhibit_i), .gate_o(gate_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic count_to_level(input logic lvl, output int n);
      n = -1;
      for (int i = 1; i <= 4 * RST_C; i++) begin
         @(negedge clk);
         if (gate_o === lvl) begin
            n = i;
            break;
         end
      end
   endtask

   // R1, R2
   task automatic t_reset_start();
      int n;
      cycles(3);
      check(gate_o === 1'b0, "R1 gate during reset", gate_o, 0);
      rst_n = 1'b1;
      cycles(1);
      check(gate_o === 1'b0, "R1 gate after release", gate_o, 0);
      count_to_level(1'b1, n);
      check(n + 1 == RST_C, "R2 first restart pulse", n + 1, RST_C);
   endtask

   // R4: trip applied at the instant of turn-on
   task automatic t_blanking();
      int n;
      trip_i = 1'b1;
      count_to_level(1'b0, n);
      check(n == ON_BLANKED, "R4 blanked on-time", n, ON_BLANKED);
      trip_i = 1'b0;
   endtask

   // R6: zero-current turn-on
   task automatic t_zcd_turn_on();
      int n;
      zcd_i = 1'b1;
      cycles(6);
      check(gate_o === 1'b0, "R6 high level alone", gate_o, 0);
      zcd_i = 1'b0;
      count_to_level(1'b1, n);
      check(n == LAT_ZCD, "R6 zcd turn-on latency", n, LAT_ZCD);
   endtask

   // R5, R7, R3
   task automatic t_filter_and_trip();
      int n;
      cycles(BLANK + 2);
      trip_i = 1'b1;
      cycles(FILT - 1);
      trip_i = 1'b0;
      zcd_i = 1'b1;
      cycles(3);
      zcd_i = 1'b0;
      cycles(8);
      check(gate_o === 1'b1, "R5 short trip ignored", gate_o, 1);
      trip_i = 1'b1;
      count_to_level(1'b0, n);
      check(n == LAT_TRIP, "R3 trip turn-off latency", n, LAT_TRIP);
      trip_i = 1'b0;
   endtask

   // R7: no arming from the on-time edge, timer restarts
   task automatic t_stale_zcd();
      int n;
      count_to_level(1'b1, n);
      check(n == RST_C, "R7 restart after turn-off", n, RST_C);
   endtask

   // R10: held trip beats zero-current edge and timer expiry
   task automatic t_clear_wins();
      int n;
      int bad = 0;
      cycles(BLANK + 2);
      trip_i = 1'b1;
      count_to_level(1'b0, n);
      zcd_i = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (gate_o !== 1'b0) bad++;
      end
      zcd_i = 1'b0;
      for (int i = 0; i < RST_C + 10; i++) begin
         @(negedge clk);
         if (gate_o !== 1'b0) bad++;
      end
      check(bad == 0, "R10 gate held off by trip", bad, 0);
      trip_i = 1'b0;
      count_to_level(1'b1, n);
      check(n == LAT_ZCD, "R10 resume after trip release", n, LAT_ZCD);
   endtask

   // R9, R8
   task automatic t_inhibit();
      int n;
      int bad = 0;
      inhibit_i = 1'b1;
      cycles(1);
      check(gate_o === 1'b0, "R9 inhibit next edge", gate_o, 0);
      for (int i = 0; i < 2 * RST_C; i++) begin
         zcd_i = (i % 8) < 4;
         @(negedge clk);
         if (gate_o !== 1'b0) bad++;
      end
      zcd_i = 1'b0;
      check(bad == 0, "R9 held off under inhibit", bad, 0);
      inhibit_i = 1'b0;
      count_to_level(1'b1, n);
      check(n == 1, "R8 restart at release", n, 1);
   endtask

   initial begin
      t_reset_start();
      t_blanking();
      t_zcd_turn_on();
      t_filter_and_trip();
      t_stale_zcd();
      t_clear_wins();
      t_inhibit();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule